// File: doc/BRIEF.md
# ADC Sample Clock-Domain Bridge

This block moves converter sample words from a slow write clock (nominally 20 MHz) into a fast processing clock (nominally 100 MHz). On the write side a free-running cycle counter fires a one-cycle store strobe once every `STROBE_PERIOD` write cycles and latches the word on `sample_in` at that moment. Each latched word goes into a small dual-clock FIFO whose pointers cross between the domains in Gray code through two-flop synchronisers.

The read side is first-word-fall-through. The oldest word waits on `rd_data` while `rd_valid` is high. A read pulse on `rd_got` takes that word and brings up the next one. The writer supplies only one word per `STROBE_PERIOD` slow cycles, so a reader that keeps `rd_got` high sees `rd_valid` as short pulses many read cycles apart. `wr_full` therefore stays low in normal use. If a strobe does meet a full buffer, the word is dropped and a sticky overflow flag records the loss. Each clock domain has its own active-low reset.

Top module: `adc_cdc_bridge`

## Requirements
- R1: After write reset is released, the store strobe fires on every `STROBE_PERIOD`-th write clock edge (edges 16, 32, 48, ... with the default). It captures the value `sample_in` holds at that edge, and that value is the word stored.
- R2: Every stored word reaches `rd_data` exactly once, in the order it was captured.
- R3: While at least one word is held, `rd_valid` is 1 and `rd_data` already shows the oldest word, with no read request needed.
- R4: `rd_got` sampled while `rd_valid` is 0 has no effect. No word is lost or skipped, and the first word written afterwards is still delivered first.
- R5: While `rd_valid` is 1 and `rd_got` is 0, `rd_valid` stays 1 and `rd_data` stays unchanged on the next read clock edge.
- R6: `wr_full` is 1 once `DEPTH` words are held and not yet read. A strobe that meets `wr_full` = 1 stores nothing, and that word is never delivered. `wr_full` stays 0 while the reader keeps up.
- R7: `wr_overflow` becomes 1 on the write edge where a strobe meets a full buffer. It stays 1 until write reset, even after the buffer drains.
- R8: With both resets asserted, `rd_valid`, `wr_full` and `wr_overflow` are 0. After reset, `rd_valid` stays 0 until the first word has been written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Converter-side clock |
| wr_rst_n | input | 1 | Active-low asynchronous reset of the write domain |
| sample_in | input | DATA_W | Converter sample word, captured on each strobe |
| wr_full | output | 1 | Buffer holds DEPTH words (write domain) |
| wr_overflow | output | 1 | Sticky flag: a strobe met a full buffer |
| rd_clk | input | 1 | Processing-side clock |
| rd_rst_n | input | 1 | Active-low asynchronous reset of the read domain |
| rd_got | input | 1 | Consume the word on rd_data when rd_valid is 1 |
| rd_valid | output | 1 | At least one word is held and shown on rd_data |
| rd_data | output | DATA_W | Oldest held word (first-word-fall-through) |

## Verification
The properties assume that the two resets are asserted together and only while the buffer is empty. If one side is reset alone, its pointer disagrees with the other side's, and the hold and sticky-flag properties no longer describe a valid buffer. The properties also assume that `rd_got` may toggle freely and needs no relation to `rd_valid`. The stimulus keeps to this. It drains the buffer before the joint reset, releases the read reset first, and drives `rd_got` high through long stretches with no data, so that the ignore case is covered. Sample values change on every write cycle, so a capture on the wrong edge shows up as a wrong word in the scoreboard.

// File: rtl/adc_cdc_pkg.sv
package adc_cdc_pkg;
    localparam int unsigned DEF_DATA_W        = 12;
    localparam int unsigned DEF_DEPTH         = 4;
    localparam int unsigned DEF_STROBE_PERIOD = 16;
endpackage

// File: rtl/adc_strobe_gen.sv
module adc_strobe_gen #(
    parameter int unsigned DATA_W = adc_cdc_pkg::DEF_DATA_W,
    parameter int unsigned PERIOD = adc_cdc_pkg::DEF_STROBE_PERIOD
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] sample_i,
    output logic              strobe_o,
    output logic [DATA_W-1:0] word_o
);
    localparam int unsigned CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;

    typedef struct packed {
        logic [CW-1:0]     cnt;
        logic              strobe;
        logic [DATA_W-1:0] word;
    } state_t;

    state_t s_d, s_q;

    always_comb begin
        s_d        = s_q;
        s_d.strobe = 1'b0;
        if (s_q.cnt == CW'(PERIOD - 1)) begin
            s_d.cnt    = '0;
            s_d.strobe = 1'b1;
            s_d.word   = sample_i;
        end else begin
            s_d.cnt = s_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign strobe_o = s_q.strobe;
    assign word_o   = s_q.word;
endmodule

// File: rtl/cdc_sync2.sv
module cdc_sync2 #(
    parameter int unsigned W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    typedef struct packed {
        logic [W-1:0] meta;
        logic [W-1:0] sync;
    } state_t;

    state_t s_d, s_q;

    always_comb begin
        s_d.meta = d_i;
        s_d.sync = s_q.meta;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign q_o = s_q.sync;
endmodule

// File: rtl/cdc_fifo_ram.sv
module cdc_fifo_ram #(
    parameter int unsigned DATA_W = adc_cdc_pkg::DEF_DATA_W,
    parameter int unsigned DEPTH  = adc_cdc_pkg::DEF_DEPTH,
    localparam int unsigned AW    = $clog2(DEPTH)
) (
    input  logic              wclk,
    input  logic              we_i,
    input  logic [AW-1:0]     waddr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [AW-1:0]     raddr_i,
    output logic [DATA_W-1:0] rdata_o
);
    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge wclk) begin
        if (we_i) mem_q[waddr_i] <= wdata_i;
    end

    assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/cdc_fifo_wr_side.sv
module cdc_fifo_wr_side #(
    parameter int unsigned DATA_W = adc_cdc_pkg::DEF_DATA_W,
    parameter int unsigned AW     = 2,
    localparam int unsigned PW    = AW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              put_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic [PW-1:0]     rd_gray_sync_i,
    output logic [PW-1:0]     wr_gray_o,
    output logic              full_o,
    output logic              ovf_o,
    output logic              we_o,
    output logic [AW-1:0]     waddr_o,
    output logic [DATA_W-1:0] wdata_o
);
    typedef struct packed {
        logic [PW-1:0] bin;
        logic [PW-1:0] gray;
        logic          ovf;
    } state_t;

    state_t s_d, s_q;
    logic   full;
    logic   accept;

    // buffer is full when the pointers differ only in the two top Gray bits
    assign full   = (s_q.gray == {~rd_gray_sync_i[PW-1:PW-2], rd_gray_sync_i[PW-3:0]});
    assign accept = put_i && !full;

    always_comb begin
        s_d = s_q;
        if (accept) begin
            s_d.bin  = s_q.bin + PW'(1);
            s_d.gray = s_d.bin ^ (s_d.bin >> 1);
        end
        if (put_i && full) s_d.ovf = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign wr_gray_o = s_q.gray;
    assign full_o    = full;
    assign ovf_o     = s_q.ovf;
    assign we_o      = accept;
    assign waddr_o   = s_q.bin[AW-1:0];
    assign wdata_o   = data_i;
endmodule

// File: rtl/cdc_fifo_rd_side.sv
module cdc_fifo_rd_side #(
    parameter int unsigned AW  = 2,
    localparam int unsigned PW = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          got_i,
    input  logic [PW-1:0] wr_gray_sync_i,
    output logic [PW-1:0] rd_gray_o,
    output logic [AW-1:0] raddr_o,
    output logic          valid_o
);
    typedef struct packed {
        logic [PW-1:0] bin;
        logic [PW-1:0] gray;
    } state_t;

    state_t s_d, s_q;
    logic   valid;

    assign valid = (s_q.gray != wr_gray_sync_i);

    always_comb begin
        s_d = s_q;
        if (got_i && valid) begin
            s_d.bin  = s_q.bin + PW'(1);
            s_d.gray = s_d.bin ^ (s_d.bin >> 1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rd_gray_o = s_q.gray;
    assign raddr_o   = s_q.bin[AW-1:0];
    assign valid_o   = valid;
endmodule

// File: rtl/adc_cdc_bridge.sv
module adc_cdc_bridge #(
    parameter int unsigned DATA_W        = adc_cdc_pkg::DEF_DATA_W,
    parameter int unsigned DEPTH         = adc_cdc_pkg::DEF_DEPTH,
    parameter int unsigned STROBE_PERIOD = adc_cdc_pkg::DEF_STROBE_PERIOD
) (
    input  logic              wr_clk,
    input  logic              wr_rst_n,
    input  logic [DATA_W-1:0] sample_in,
    output logic              wr_full,
    output logic              wr_overflow,
    input  logic              rd_clk,
    input  logic              rd_rst_n,
    input  logic              rd_got,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);
    // DEPTH: power of two, at least 4
    localparam int unsigned AW = $clog2(DEPTH);
    localparam int unsigned PW = AW + 1;

    logic              wr_strobe;
    logic [DATA_W-1:0] wr_word;
    logic [PW-1:0]     wr_gray, wr_gray_rsync;
    logic [PW-1:0]     rd_gray, rd_gray_wsync;
    logic              ram_we;
    logic [AW-1:0]     ram_waddr, ram_raddr;
    logic [DATA_W-1:0] ram_wdata;

    adc_strobe_gen #(.DATA_W(DATA_W), .PERIOD(STROBE_PERIOD)) u_strobe (
        .clk(wr_clk), .rst_n(wr_rst_n), .sample_i(sample_in),
        .strobe_o(wr_strobe), .word_o(wr_word)
    );

    cdc_fifo_wr_side #(.DATA_W(DATA_W), .AW(AW)) u_wr (
        .clk(wr_clk), .rst_n(wr_rst_n), .put_i(wr_strobe), .data_i(wr_word),
        .rd_gray_sync_i(rd_gray_wsync), .wr_gray_o(wr_gray),
        .full_o(wr_full), .ovf_o(wr_overflow),
        .we_o(ram_we), .waddr_o(ram_waddr), .wdata_o(ram_wdata)
    );

    cdc_sync2 #(.W(PW)) u_sync_r2w (
        .clk(wr_clk), .rst_n(wr_rst_n), .d_i(rd_gray), .q_o(rd_gray_wsync)
    );

    cdc_sync2 #(.W(PW)) u_sync_w2r (
        .clk(rd_clk), .rst_n(rd_rst_n), .d_i(wr_gray), .q_o(wr_gray_rsync)
    );

    cdc_fifo_ram #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_ram (
        .wclk(wr_clk), .we_i(ram_we), .waddr_i(ram_waddr), .wdata_i(ram_wdata),
        .raddr_i(ram_raddr), .rdata_o(rd_data)
    );

    cdc_fifo_rd_side #(.AW(AW)) u_rd (
        .clk(rd_clk), .rst_n(rd_rst_n), .got_i(rd_got),
        .wr_gray_sync_i(wr_gray_rsync), .rd_gray_o(rd_gray),
        .raddr_o(ram_raddr), .valid_o(rd_valid)
    );
endmodule

// File: rtl/adc_cdc_bridge_sva.sv
module adc_cdc_bridge_sva #(
    parameter int unsigned DATA_W = 12,
    parameter int unsigned PERIOD = 16
) (
    input logic              wr_clk,
    input logic              wr_rst_n,
    input logic              rd_clk,
    input logic              rd_rst_n,
    input logic              strobe,
    input logic              full,
    input logic              ovf,
    input logic              got,
    input logic              valid,
    input logic [DATA_W-1:0] data
);
    int unsigned gap_q;

    always_ff @(posedge wr_clk or negedge wr_rst_n) begin
        if (!wr_rst_n)          gap_q <= 0;
        else if (strobe)        gap_q <= 1;
        else if (gap_q <= PERIOD) gap_q <= gap_q + 1;
    end

    // R1: strobe spacing equals the period, counted from reset
    a_r1_strobe_spacing: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        strobe |-> (gap_q == PERIOD));

    // R1: strobe lasts a single write cycle
    a_r1_strobe_single: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        strobe |=> !strobe);

    // R5: held word stays put until consumed
    a_r5_hold_word: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        (valid && !got) |=> (valid && $stable(data)));

    // R7: overflow is sticky
    a_r7_ovf_sticky: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        ovf |=> ovf);

    // R7: overflow only rises after a strobe met a full buffer
    a_r7_ovf_cause: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        $rose(ovf) |-> $past(strobe && full));

    // R6: a strobe meeting full always leaves the flag set
    a_r6_drop_flagged: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        (strobe && full) |=> ovf);
endmodule

bind adc_cdc_bridge adc_cdc_bridge_sva #(.DATA_W(DATA_W), .PERIOD(STROBE_PERIOD)) u_sva (
    .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .rd_clk(rd_clk), .rd_rst_n(rd_rst_n),
    .strobe(wr_strobe), .full(wr_full), .ovf(wr_overflow),
    .got(rd_got), .valid(rd_valid), .data(rd_data)
);

// File: tb/tb_adc_cdc_bridge.sv
`timescale 1ns/100ps
module tb_adc_cdc_bridge;
    localparam int DW  = 12;
    localparam int DEP = 4;
    localparam int PER = 16;

    logic          rd_clk = 1'b0, wr_clk = 1'b0;
    logic          rd_rst_n = 1'b0, wr_rst_n = 1'b0;
    logic          got = 1'b0;
    logic [DW-1:0] sample = '0;
    logic          full, ovf, valid;
    logic [DW-1:0] data;

    int errors = 0, checks = 0;
    int e = 0;
    int popped = 0;
    bit accept = 1'b1;
    bit mon_en = 1'b1;
    logic [DW-1:0] expq[$];

    adc_cdc_bridge #(.DATA_W(DW), .DEPTH(DEP), .STROBE_PERIOD(PER)) dut (
        .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .sample_in(sample),
        .wr_full(full), .wr_overflow(ovf),
        .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_got(got),
        .rd_valid(valid), .rd_data(data)
    );

    always #2 rd_clk = ~rd_clk;                       // 250 MHz
    initial begin #1.3; forever #10.5 wr_clk = ~wr_clk; end

    function automatic logic [DW-1:0] pat(int n);
        return DW'((n * 37 + 11) ^ (n >> 3));
    endfunction

    task automatic check_eq(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // driver: new sample each write cycle, expected word queued per strobe
    task automatic drive_samples();
        forever begin
            @(negedge wr_clk);
            sample = pat(e + 1);
            @(posedge wr_clk);
            if (!wr_rst_n) e = 0;
            else begin
                e++;
                if ((e % PER) == 0 && accept) expq.push_back(pat(e));
            end
        end
    endtask

    // monitor / scoreboard
    always @(negedge rd_clk) begin
        if (rd_rst_n && mon_en && valid) begin
            if (expq.size() == 0) check_eq("R8 valid with nothing written", 1, 0);
            else begin
                check_eq("R1 R2 word order", int'(data), int'(expq.pop_front()));
                popped++;
            end
        end
        got = mon_en;
    end

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (150000) @(posedge rd_clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    task automatic release_resets();
        @(negedge rd_clk); rd_rst_n = 1'b1;
        @(negedge wr_clk); wr_rst_n = 1'b1;
    endtask

    initial begin
        logic [DW-1:0] d0;
        bit held_ok;
        fork drive_samples(); join_none
        #40;
        @(negedge rd_clk);
        check_eq("R8 reset valid", valid, 0);
        check_eq("R8 reset full", full, 0);
        check_eq("R8 reset overflow", ovf, 0);
        release_resets();

        // phase A: reader always requesting (R4: got high while empty)
        wait (e == PER);
        @(negedge rd_clk);
        check_eq("R8 no valid before first write", valid, 0);
        check_eq("R8 nothing popped before first write", popped, 0);
        wait (e == PER + 8);
        @(negedge wr_clk);
        check_eq("R4 first word delivered despite early got", popped, 1);
        wait (e == PER * 8 + 8);
        @(negedge wr_clk);
        check_eq("R2 all words delivered", popped, 8);
        check_eq("R6 full low while draining", full, 0);
        check_eq("R7 no overflow in normal flow", ovf, 0);

        // phase B: reader stalls, buffer fills
        mon_en = 1'b0;
        wait (e == PER * 11 + 1);
        repeat (12) @(negedge rd_clk);
        check_eq("R3 valid with words held", valid, 1);
        check_eq("R3 oldest word shown", int'(data), int'(expq[0]));
        d0 = data;
        held_ok = 1'b1;
        repeat (20) begin
            @(negedge rd_clk);
            if (!valid || data != d0) held_ok = 1'b0;
        end
        check_eq("R5 word held without got", held_ok, 1);
        @(negedge wr_clk);
        check_eq("R6 not full with 3 words", full, 0);
        wait (e == PER * 12 + 1);
        @(negedge wr_clk);
        check_eq("R6 full with DEPTH words", full, 1);
        check_eq("R7 no overflow yet", ovf, 0);
        accept = 1'b0;
        wait (e == PER * 13 + 1);
        @(negedge wr_clk);
        accept = 1'b1;
        check_eq("R7 overflow set on drop", ovf, 1);
        check_eq("R6 still full", full, 1);
        check_eq("R6 dropped word not queued", expq.size(), 4);

        // drain and continue
        mon_en = 1'b1;
        wait (e == PER * 16 + 8);
        @(negedge wr_clk);
        check_eq("R2 R6 delivered count skips dropped word", popped, 15);
        check_eq("R2 scoreboard empty", expq.size(), 0);
        check_eq("R6 full clears after drain", full, 0);
        check_eq("R7 overflow sticky after drain", ovf, 1);

        // joint reset with empty buffer
        @(negedge wr_clk);
        wr_rst_n = 1'b0; rd_rst_n = 1'b0;
        repeat (3) @(negedge wr_clk);
        check_eq("R7 overflow cleared by write reset", ovf, 0);
        check_eq("R8 full after reset", full, 0);
        check_eq("R8 valid after reset", valid, 0);
        release_resets();
        wait (e == PER * 3 + 8);
        @(negedge wr_clk);
        check_eq("R2 delivery after reset", popped, 18);
        check_eq("R7 overflow stays clear", ovf, 0);

        summary();
        $finish;
    end
endmodule